// File: doc/BRIEF.md
# Masked-Write GPIO Port Registers

This block is a 24-line general purpose I/O port. Its lines are split into three banks of eight, and line n belongs to bank n/8 at bit n%8. Software reaches the port over a simple byte-wide register bus. Each bank has an output latch, a direction register and a live input view. Input pins pass through a two-flop synchronizer before anything reads them. The block drives the pin output values and the per-line output enables.

An output update takes two bus writes. The first write carries a value byte and goes to the bank's value address. The second write carries a mask byte and goes to the address just above it. Only the bits set in the mask take the new value, so one pin can change without a read-modify-write. A value byte stays pending, across any number of idle cycles, until the matching mask byte arrives. Any other bus access drops it.

A hold bit in a control register keeps the whole port in reset. It is set when the block leaves reset, and software clears it to start the port.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, every output enable and every output value is 0. A read of the control address 0x0F returns 0x01, meaning the hold bit is set.
- R2: While the hold bit (address 0x0F, bit 0) is 1, all output latches and direction bits are held at 0 and data and direction writes are ignored. Reads of the data and direction addresses return 0. Writing 1 to the hold bit clears the latches and direction bits at the same clock edge as the write. Writing 0 starts the port.
- R3: The direction register of bank b is at address 0x08+b and reads back its value. A 1 bit makes the corresponding line an output, so pin_oe[8b+i] follows bit i.
- R4: For bank b, the value address is 2b and the mask address is 2b+1. A value write followed by a mask write to the same bank sets pin_out[8b+i] to the value bit wherever mask bit i is 1 and leaves every other bit unchanged. Idle bus cycles may fall between the two writes.
- R5: A pending value byte is discarded by any bus access that is not its own mask write: a read, a write to another address, or a mask write for a different bank. A mask write with no pending value changes nothing.
- R6: A read of address 2b returns the synchronized levels of the bank's eight pins, bit i for line 8b+i. A pin level must be stable for two clock edges before a read's capture edge for the read to see it. Read data is registered and appears after the edge that captures the read.
- R7: An output latch keeps its value whatever the line's direction. Latches update while the line is an input, and setting the direction bit drives the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Pin levels from the pads |
| pin_out | output | 24 | Output latch values |
| pin_oe | output | 24 | Per-line output enable |

## Verification
Writes to direction, mask and control take effect at the clock edge that samples the access, and the bench checks pin_out and pin_oe at the next falling edge. A value write alone must leave the pins untouched at that sample. Read data is checked at the falling edge after the capture edge. Before any data read, the bench holds pin_in steady for two extra clock edges so the synchronizer has settled, which matches the two-flop latency in R6.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t CTRL_ADDR = 8'h0F;
  localparam byte_t DIR_BASE  = 8'h08;

  function automatic byte_t value_addr(input int b);
    return byte_t'(2 * b);
  endfunction

  function automatic byte_t mask_addr(input int b);
    return byte_t'(2 * b + 1);
  endfunction

  function automatic byte_t dir_addr(input int b);
    return byte_t'(DIR_BASE + byte_t'(b));
  endfunction

  // new bits where mask is 1, old bits elsewhere
  function automatic byte_t masked_merge(input byte_t old_v, input byte_t new_v,
                                         input byte_t mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_mask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  commit,
  input  byte_t val,
  input  byte_t mask,
  input  logic  dir_we,
  input  byte_t dir_wdata,
  output byte_t out_q,
  output byte_t dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (clr) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (commit) out_q <= masked_merge(out_q, val, mask);
      if (dir_we) dir_q <= dir_wdata;
    end
  end

  // R4: unmasked bits never move on a commit
  assert_unmasked_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !clr |=> ((out_q ^ $past(out_q)) & ~$past(mask)) == '0);

  // R7: latch only moves on a commit or a clear, regardless of direction
  assert_latch_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit && !clr |=> $stable(out_q));

  // R3: direction only moves on its own write
  assert_dir_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we && !clr |=> $stable(dir_q));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_cs,
  input  logic                   bus_we,
  input  logic [7:0]             bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic [NUM_BANKS*8-1:0] pin_in,
  output logic [NUM_BANKS*8-1:0] pin_out,
  output logic [NUM_BANKS*8-1:0] pin_oe
);
  localparam int LINES = NUM_BANKS * 8;
  localparam int BW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic wr, rd, ctrl_wr;
  logic hold_q, hold_nxt;
  logic [NUM_BANKS-1:0] val_hit, mask_hit, dir_hit, commit;
  logic pend_vld;
  logic [BW-1:0] pend_bank, hit_bank;
  byte_t pend_val, rd_val;
  logic [LINES-1:0] pin_sync;

  assign wr       = bus_cs && bus_we;
  assign rd       = bus_cs && !bus_we;
  assign ctrl_wr  = wr && (bus_addr == CTRL_ADDR);
  assign hold_nxt = ctrl_wr ? bus_wdata[0] : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b1;
    else        hold_q <= hold_nxt;
  end

  gpio_mask_sync #(.W(LINES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign val_hit[b]  = wr && !hold_q && (bus_addr == value_addr(b));
    assign mask_hit[b] = wr && !hold_q && (bus_addr == mask_addr(b));
    assign dir_hit[b]  = wr && !hold_q && (bus_addr == dir_addr(b));
    assign commit[b]   = mask_hit[b] && pend_vld && (pend_bank == BW'(b));

    gpio_mask_bank i_bank (
      .clk(clk), .rst_n(rst_n), .clr(hold_nxt),
      .commit(commit[b]), .val(pend_val), .mask(bus_wdata),
      .dir_we(dir_hit[b]), .dir_wdata(bus_wdata),
      .out_q(pin_out[b*8 +: 8]), .dir_q(pin_oe[b*8 +: 8])
    );
  end

  always_comb begin
    hit_bank = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (val_hit[b]) hit_bank = BW'(b);
  end

  // pending value byte: set by a value write, dropped by any other access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_bank <= '0;
      pend_val  <= '0;
    end else if (bus_cs) begin
      pend_vld <= (|val_hit) && !hold_nxt;
      if (|val_hit) begin
        pend_bank <= hit_bank;
        pend_val  <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == CTRL_ADDR) rd_val = {7'b0, hold_q};
    else if (!hold_q) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr == value_addr(b)) rd_val = pin_sync[b*8 +: 8];
        if (bus_addr == dir_addr(b))   rd_val = pin_oe[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
  end

  // R2: held port drives nothing
  assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (pin_oe == '0) && (pin_out == '0));

  // R5: any access other than a value write leaves nothing pending
  assert_pend_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs && !(|val_hit) |=> !pend_vld);

  // R5: at most one bank commits, and only with a pending value
  assert_commit_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit) |-> $onehot0(commit) && pend_vld && !hold_q);

  // R6: read data changes only on a read
  assert_rdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_gpio_mask_port.sv
`timescale 1ns/1ps
module test_gpio_mask_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cs = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic [23:0] pin_in = '0, pin_out, pin_oe;

  int checks = 0, fails = 0;
  logic [7:0] m_out[3], m_dir[3];
  logic m_hold, m_pv;
  int m_pb;
  logic [7:0] m_pval;

  always #4 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [7:0] bit_merge(logic [7:0] o, logic [7:0] v, logic [7:0] m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m[i] ? v[i] : o[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    check({tag, " pin_out"}, pin_out, {m_out[2], m_out[1], m_out[0]});
    check({tag, " pin_oe"},  pin_oe,  {m_dir[2], m_dir[1], m_dir[0]});
  endtask

  task automatic model_reset();
    for (int b = 0; b < 3; b++) begin m_out[b] = '0; m_dir[b] = '0; end
    m_hold = 1'b1; m_pv = 1'b0; m_pb = 0; m_pval = '0;
  endtask

  task automatic bus_op(input bit we, input logic [7:0] a, input logic [7:0] d, input string tag);
    logic [7:0] exp_rd;
    int b;
    b = a / 2;
    exp_rd = 8'h00;
    if (a == 8'h0F) exp_rd = {7'b0, m_hold};
    else if (!m_hold && a < 6 && a[0] == 1'b0) exp_rd = pin_in[b*8 +: 8];
    else if (!m_hold && a >= 8 && a <= 10) exp_rd = m_dir[a-8];
    if (we) begin
      if (a == 8'h0F) begin
        m_hold = d[0];
        if (d[0]) for (int k = 0; k < 3; k++) begin m_out[k] = '0; m_dir[k] = '0; end
        m_pv = 1'b0;
      end else if (m_hold) m_pv = 1'b0;
      else if (a < 6 && a[0] == 1'b0) begin
        m_pv = 1'b1; m_pb = b; m_pval = d;
      end else begin
        if (a < 6 && m_pv && m_pb == b) m_out[b] = bit_merge(m_out[b], m_pval, d);
        if (a >= 8 && a <= 10) m_dir[a-8] = d;
        m_pv = 1'b0;
      end
    end else m_pv = 1'b0;
    @(negedge clk);
    bus_cs = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0;
    check_pins(tag);
    if (!we) check({tag, " rdata"}, {16'h0, bus_rdata}, {16'h0, exp_rd});
  endtask

  task automatic set_pins(input logic [23:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 reset");
    bus_op(0, 8'h0F, 8'h00, "R1 hold read");

    // R2: writes ignored while held
    set_pins(24'h5A_C3_A5);
    bus_op(1, 8'h08, 8'hFF, "R2 dir held");
    bus_op(1, 8'h00, 8'hFF, "R2 val held");
    bus_op(1, 8'h01, 8'hFF, "R2 mask held");
    bus_op(0, 8'h00, 8'h00, "R2 data read held");
    bus_op(1, 8'h0F, 8'h00, "R2 release");

    // R3 direction
    bus_op(1, 8'h09, 8'hF0, "R3 dir1 write");
    bus_op(0, 8'h09, 8'h00, "R3 dir1 read");

    // R4 masked update with idle gap
    bus_op(1, 8'h02, 8'h3C, "R4 val1");
    repeat (3) @(negedge clk);
    bus_op(1, 8'h03, 8'h0F, "R4 mask1");
    bus_op(1, 8'h04, 8'hFF, "R4 val2");
    bus_op(1, 8'h05, 8'h81, "R4 mask2");

    // R5 discards
    bus_op(1, 8'h04, 8'h00, "R5 val2");
    bus_op(0, 8'h0F, 8'h00, "R5 read between");
    bus_op(1, 8'h05, 8'hFF, "R5 stale mask");
    bus_op(1, 8'h00, 8'hFF, "R5 val0");
    bus_op(1, 8'h03, 8'hFF, "R5 other mask");
    bus_op(1, 8'h01, 8'hFF, "R5 mask no pending");

    // R6 reads of synchronized pins
    set_pins(24'h12_34_56);
    bus_op(0, 8'h00, 8'h00, "R6 bank0");
    bus_op(0, 8'h02, 8'h00, "R6 bank1");
    bus_op(0, 8'h04, 8'h00, "R6 bank2");
    bus_op(0, 8'h05, 8'h00, "R6 mask addr");

    // R7 latch kept across direction
    bus_op(1, 8'h0A, 8'h00, "R7 dir2 input");
    bus_op(1, 8'h04, 8'h6E, "R7 val2");
    bus_op(1, 8'h05, 8'hFF, "R7 mask2");
    bus_op(1, 8'h0A, 8'hFF, "R7 dir2 output");

    // R2 re-hold clears at once
    bus_op(1, 8'h0F, 8'h01, "R2 rehold");
    bus_op(1, 8'h0F, 8'h00, "R2 release again");

    for (int n = 0; n < 600; n++) begin
      int sel;
      int bk;
      if (n % 8 == 0) set_pins(24'($urandom));
      sel = int'($urandom_range(0, 9));
      bk  = int'($urandom_range(0, 2));
      if (sel < 4) begin
        bus_op(1, 8'(2*bk), 8'($urandom), "R4 rnd val");
        if ($urandom_range(0, 3) != 0)
          bus_op(1, 8'(2*($urandom_range(0, 3) == 0 ? (bk+1)%3 : bk) + 1), 8'($urandom), "R5 rnd mask");
      end else if (sel < 6) bus_op(1, 8'(8+bk), 8'($urandom), "R3 rnd dir");
      else if (sel < 8) bus_op(0, 8'(2*bk), 8'h00, "R6 rnd read");
      else if (sel == 8) bus_op(0, 8'(8+bk), 8'h00, "R3 rnd dir read");
      else bus_op(1, 8'h0F, ($urandom_range(0, 7) == 0) ? 8'h01 : 8'h00, "R2 rnd hold");
    end
    finish_run();
  end
endmodule